// File: doc/BRIEF.md
# Bitfield and Byte-Select Execution Unit

This is a single-cycle integer execution unit for a 32-bit core. It covers a group of bit-manipulation and miscellaneous data operations: clearing a contiguous bit range, inserting a field into a range, signed and unsigned field extraction, counting leading zeros, writing the upper half-word from an immediate, and building a word one byte at a time from two sources under four per-byte flags.

Decode provides the operation code, two register values, two 5-bit position fields, a 16-bit immediate, a condition-passed bit, the four byte-select flags and two program-counter usage flags. One clock edge after a valid input, the unit presents the result, a register write-enable, and a flag that marks the operation as unpredictable. An unpredictable operation never writes. A failed condition also blocks the write, but it does not raise the unpredictable flag.

Operand roles are as follows. `dst_val` is the current destination value, and it is also the first source of byte select. `src_val` is the source of insert, extract and count-leading-zeros, and the second source of byte select.

Top module: `bitop_exec`

## Requirements
- R1: Opcode 0 (clear) produces `dst_val` with bits `pos_lo`..`pos_hi` forced to zero. Every other bit is unchanged.
- R2: Opcode 1 (insert) places the low (`pos_hi`-`pos_lo`+1) bits of `src_val` at bit positions `pos_lo`..`pos_hi` of `dst_val`. Every other bit of `dst_val` is kept.
- R3: For opcodes 0 and 1, `pos_hi` < `pos_lo` raises `out_unpred` and leaves `out_wen` low.
- R4: Opcode 6 (unsigned extract) returns `src_val` bits `pos_lo`..`pos_lo`+`pos_hi`, zero-extended. Here `pos_hi` holds the width minus one.
- R5: Opcode 4 (signed extract) returns the same field as R4, sign-extended from its top bit.
- R6: For opcodes 4 and 6, `pos_lo`+`pos_hi` ≥ 32 raises `out_unpred` and leaves `out_wen` low.
- R7: Opcode 2 returns the number of zero bits above the highest set bit of `src_val`. The value is 32 when `src_val` is zero.
- R8: Opcode 3 (move-top) returns `imm_val` in bits 31:16 and `dst_val[15:0]` in bits 15:0.
- R9: Opcode 5 (byte select) takes result byte i (bits 8i+7..8i) from `dst_val` when `ge_flags[i]` is 1, and from `src_val` when it is 0.
- R10: `dst_is_pc` makes every opcode unpredictable. `src_is_pc` makes opcodes 2, 4, 5 and 6 unpredictable and has no effect on opcodes 0, 1 and 3.
- R11: With `cond_ok` low, a valid input gives `out_wen` low. `out_unpred` still reflects the unpredictable rules.
- R12: Outputs are registered one cycle after `in_valid`. When `in_valid` is low, the next cycle has `out_wen` and `out_unpred` low. Reset clears all outputs to zero.
- R13: Opcode 7 is reserved and always raises `out_unpred`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_sel | input | 3 | Operation code (see requirements) |
| dst_val | input | 32 | Destination current value / first select source |
| src_val | input | 32 | Source operand / second select source |
| pos_lo | input | 5 | Low bit position |
| pos_hi | input | 5 | High bit position, or width minus one for extracts |
| imm_val | input | 16 | Move-top immediate |
| cond_ok | input | 1 | Condition passed |
| ge_flags | input | 4 | Per-byte select flags |
| dst_is_pc | input | 1 | Destination is the program counter |
| src_is_pc | input | 1 | A source is the program counter |
| out_result | output | 32 | Registered result |
| out_wen | output | 1 | Registered write-enable |
| out_unpred | output | 1 | Registered unpredictable flag |

## Verification
The bound checker evaluates the following on every cycle:
- the one-cycle timing of write-enable and the unpredictable flag;
- their mutual exclusion;
- the PC-destination, reserved-opcode and clear/insert ordering rules;
- the exact move-top result.

The arithmetic results of clear, insert, both extracts, count-leading-zeros and byte select are checked only by the directed scenarios. These scenarios use hand-computed values at the field edges: single-bit and full-width fields, the top bit position, and a zero input to count-leading-zeros.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
   typedef enum logic [2:0] {
      OP_BCLR  = 3'd0,
      OP_BINS  = 3'd1,
      OP_CLZ   = 3'd2,
      OP_MOVHI = 3'd3,
      OP_SXTF  = 3'd4,
      OP_BSEL  = 3'd5,
      OP_UXTF  = 3'd6,
      OP_RSVD  = 3'd7
   } bitop_op_e;
endpackage

// File: rtl/bitop_check.sv
module bitop_check import bitop_pkg::*; #(
   parameter int DATA_W = 32,
   localparam int POS_W = $clog2(DATA_W)
) (
   input  logic [2:0]       op,
   input  logic [POS_W-1:0] lo,
   input  logic [POS_W-1:0] hi,
   input  logic             dst_pc,
   input  logic             src_pc,
   output logic             unpred
);
   localparam logic [POS_W:0] LIMIT = (POS_W+1)'(DATA_W);

   logic [POS_W:0] span_end;
   logic           uses_src;
   logic           range_bad;

   assign span_end = {1'b0, lo} + {1'b0, hi};

   always_comb begin
      uses_src  = 1'b0;
      range_bad = 1'b0;
      case (bitop_op_e'(op))
         OP_BCLR, OP_BINS: range_bad = (hi < lo);
         OP_SXTF, OP_UXTF: begin
            range_bad = (span_end >= LIMIT);
            uses_src  = 1'b1;
         end
         OP_CLZ, OP_BSEL:  uses_src = 1'b1;
         default: ;
      endcase
      unpred = dst_pc || (uses_src && src_pc) || range_bad ||
               (bitop_op_e'(op) == OP_RSVD);
   end
endmodule

// File: rtl/bitop_field.sv
module bitop_field import bitop_pkg::*; #(
   parameter int DATA_W = 32,
   localparam int POS_W = $clog2(DATA_W)
) (
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] dst,
   input  logic [DATA_W-1:0] src,
   input  logic [POS_W-1:0]  lo,
   input  logic [POS_W-1:0]  hi,
   output logic [DATA_W-1:0] res
);
   localparam logic [POS_W-1:0]  TOP  = POS_W'(DATA_W - 1);
   localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

   logic [DATA_W-1:0] rng_mask;
   logic [DATA_W-1:0] wid_mask;
   logic [DATA_W-1:0] ins_val;
   logic [DATA_W-1:0] ux_val;
   logic [DATA_W-1:0] sx_tmp;
   logic [DATA_W-1:0] sx_val;
   logic [POS_W-1:0]  sx_lsh;
   logic [POS_W-1:0]  sx_rsh;

   // range lo..hi, and low (hi+1) ones for extracts
   assign rng_mask = (ONES >> (TOP - hi)) & (ONES << lo);
   assign wid_mask = ONES >> (TOP - hi);

   assign ins_val  = (dst & ~rng_mask) | ((src << lo) & rng_mask);
   assign ux_val   = (src >> lo) & wid_mask;

   assign sx_lsh   = TOP - hi - lo;
   assign sx_rsh   = TOP - hi;
   assign sx_tmp   = src << sx_lsh;
   assign sx_val   = $unsigned($signed(sx_tmp) >>> sx_rsh);

   always_comb begin
      case (bitop_op_e'(op))
         OP_BCLR: res = dst & ~rng_mask;
         OP_BINS: res = ins_val;
         OP_SXTF: res = sx_val;
         OP_UXTF: res = ux_val;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/bitop_clz.sv
module bitop_clz #(
   parameter int DATA_W   = 32,
   parameter bit CLZ_TREE = 1'b1,
   localparam int POS_W   = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] val,
   output logic [POS_W:0]    cnt
);
   localparam int HALF = DATA_W / 2;

   generate
      if (CLZ_TREE) begin : g_tree
         logic [DATA_W-1:0] x;
         always_comb begin
            x   = val;
            cnt = '0;
            for (int s = HALF; s >= 1; s = s / 2) begin
               if ((x >> (DATA_W - s)) == '0) begin
                  cnt = cnt + (POS_W+1)'(s);
                  x   = x << s;
               end
            end
            if (!x[DATA_W-1]) cnt = cnt + (POS_W+1)'(1);
         end
      end else begin : g_scan
         logic seen;
         always_comb begin
            cnt  = '0;
            seen = 1'b0;
            for (int i = DATA_W - 1; i >= 0; i--) begin
               if (!seen) begin
                  if (val[i]) seen = 1'b1;
                  else        cnt  = cnt + (POS_W+1)'(1);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/bitop_exec.sv
module bitop_exec import bitop_pkg::*; #(
   parameter int DATA_W   = 32,
   parameter bit CLZ_TREE = 1'b1,
   localparam int POS_W   = $clog2(DATA_W),
   localparam int HALF    = DATA_W / 2,
   localparam int LANES   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [2:0]        op_sel,
   input  logic [DATA_W-1:0] dst_val,
   input  logic [DATA_W-1:0] src_val,
   input  logic [POS_W-1:0]  pos_lo,
   input  logic [POS_W-1:0]  pos_hi,
   input  logic [HALF-1:0]   imm_val,
   input  logic              cond_ok,
   input  logic [LANES-1:0]  ge_flags,
   input  logic              dst_is_pc,
   input  logic              src_is_pc,
   output logic [DATA_W-1:0] out_result,
   output logic              out_wen,
   output logic              out_unpred
);
   generate
      if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("bitop_exec: DATA_W must be a power of two and at least 16");
      end
   endgenerate

   logic [DATA_W-1:0] field_res;
   logic [POS_W:0]    clz_cnt;
   logic [DATA_W-1:0] sel_res;
   logic [DATA_W-1:0] movhi_res;
   logic [DATA_W-1:0] nxt_res;
   logic              unpred;

   bitop_check #(.DATA_W(DATA_W)) u_check (
      .op     (op_sel),
      .lo     (pos_lo),
      .hi     (pos_hi),
      .dst_pc (dst_is_pc),
      .src_pc (src_is_pc),
      .unpred (unpred)
   );

   bitop_field #(.DATA_W(DATA_W)) u_field (
      .op  (op_sel),
      .dst (dst_val),
      .src (src_val),
      .lo  (pos_lo),
      .hi  (pos_hi),
      .res (field_res)
   );

   bitop_clz #(.DATA_W(DATA_W), .CLZ_TREE(CLZ_TREE)) u_clz (
      .val (src_val),
      .cnt (clz_cnt)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign sel_res[8*g +: 8] = ge_flags[g] ? dst_val[8*g +: 8]
                                                : src_val[8*g +: 8];
      end
   endgenerate

   assign movhi_res = {imm_val, dst_val[HALF-1:0]};

   always_comb begin
      case (bitop_op_e'(op_sel))
         OP_CLZ:   nxt_res = DATA_W'(clz_cnt);
         OP_MOVHI: nxt_res = movhi_res;
         OP_BSEL:  nxt_res = sel_res;
         OP_RSVD:  nxt_res = '0;
         default:  nxt_res = field_res;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_result <= '0;
         out_wen    <= 1'b0;
         out_unpred <= 1'b0;
      end else begin
         out_wen    <= in_valid && cond_ok && !unpred;
         out_unpred <= in_valid && unpred;
         if (in_valid) out_result <= nxt_res;
      end
   end
endmodule

// File: rtl/bitop_exec_chk.sv
module bitop_exec_chk #(
   parameter int DATA_W = 32,
   localparam int POS_W = $clog2(DATA_W),
   localparam int HALF  = DATA_W / 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2:0]        op_sel,
   input logic [DATA_W-1:0] dst_val,
   input logic [POS_W-1:0]  pos_lo,
   input logic [POS_W-1:0]  pos_hi,
   input logic [HALF-1:0]   imm_val,
   input logic              cond_ok,
   input logic              dst_is_pc,
   input logic              src_is_pc,
   input logic [DATA_W-1:0] out_result,
   input logic              out_wen,
   input logic              out_unpred
);
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_wen && !out_unpred));

   a_r11_wen_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !cond_ok) |=> !out_wen);

   a_r3_wen_excludes_unpred: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_wen && out_unpred));

   a_r3_order_bad: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel <= 3'd1 && pos_hi < pos_lo) |=> (out_unpred && !out_wen));

   a_r10_dst_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dst_is_pc) |=> (out_unpred && !out_wen));

   a_r13_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 3'd7) |=> out_unpred);

   a_r8_move_top: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 3'd3 && cond_ok && !dst_is_pc) |=>
      (out_wen && out_result[DATA_W-1:HALF] == $past(imm_val) &&
       out_result[HALF-1:0] == $past(dst_val[HALF-1:0])));

   a_r10_src_pc_clear_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 3'd0 && src_is_pc && !dst_is_pc && cond_ok &&
       pos_hi >= pos_lo) |=> out_wen);
endmodule

bind bitop_exec bitop_exec_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .op_sel     (op_sel),
   .dst_val    (dst_val),
   .pos_lo     (pos_lo),
   .pos_hi     (pos_hi),
   .imm_val    (imm_val),
   .cond_ok    (cond_ok),
   .dst_is_pc  (dst_is_pc),
   .src_is_pc  (src_is_pc),
   .out_result (out_result),
   .out_wen    (out_wen),
   .out_unpred (out_unpred)
);

// File: tb/test_bitop_exec.sv
module test_bitop_exec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  op_sel = '0;
   logic [31:0] dst_val = '0;
   logic [31:0] src_val = '0;
   logic [4:0]  pos_lo = '0;
   logic [4:0]  pos_hi = '0;
   logic [15:0] imm_val = '0;
   logic        cond_ok = 1'b0;
   logic [3:0]  ge_flags = '0;
   logic        dst_is_pc = 1'b0;
   logic        src_is_pc = 1'b0;
   logic [31:0] out_result;
   logic        out_wen;
   logic        out_unpred;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   bitop_exec i_bitop_exec (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .dst_val(dst_val), .src_val(src_val), .pos_lo(pos_lo), .pos_hi(pos_hi),
      .imm_val(imm_val), .cond_ok(cond_ok), .ge_flags(ge_flags),
      .dst_is_pc(dst_is_pc), .src_is_pc(src_is_pc),
      .out_result(out_result), .out_wen(out_wen), .out_unpred(out_unpred)
   );

   task automatic issue(input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [4:0] lo,
                        input logic [4:0] hi, input logic [15:0] imm,
                        input logic cnd, input logic [3:0] ge,
                        input logic dpc, input logic spc);
      @(negedge clk);
      op_sel = op; dst_val = a; src_val = b; pos_lo = lo; pos_hi = hi;
      imm_val = imm; cond_ok = cnd; ge_flags = ge; dst_is_pc = dpc;
      src_is_pc = spc; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic check(input string req, input bit cmp_res,
                        input logic [31:0] exp_res, input logic exp_wen,
                        input logic exp_unp);
      n_run++;
      if (out_wen !== exp_wen || out_unpred !== exp_unp ||
          (cmp_res && out_result !== exp_res)) begin
         n_fail++;
         $display("FAIL %s: got res=%08h wen=%0b unp=%0b, expected res=%08h wen=%0b unp=%0b",
                  req, out_result, out_wen, out_unpred, exp_res, exp_wen, exp_unp);
      end
   endtask

   task automatic t_reset();
      check("R12 reset", 1'b1, 32'h0, 1'b0, 1'b0);
   endtask

   task automatic t_clear();
      issue(3'd0, 32'hFFFF_FFFF, 32'h0, 5'd4, 5'd11, 16'h0, 1, 4'h0, 0, 0);
      check("R1 clear 11:4", 1, 32'hFFFF_F00F, 1, 0);
      issue(3'd0, 32'hFFFF_FFFF, 32'h0, 5'd31, 5'd31, 16'h0, 1, 4'h0, 0, 0);
      check("R1 clear bit 31", 1, 32'h7FFF_FFFF, 1, 0);
      issue(3'd0, 32'hA5A5_A5A5, 32'h0, 5'd0, 5'd31, 16'h0, 1, 4'h0, 0, 0);
      check("R1 clear all", 1, 32'h0, 1, 0);
   endtask

   task automatic t_insert();
      issue(3'd1, 32'h1234_5678, 32'h0000_ABCD, 5'd8, 5'd15, 16'h0, 1, 4'h0, 0, 0);
      check("R2 insert 15:8", 1, 32'h1234_CD78, 1, 0);
      issue(3'd1, 32'h1234_5678, 32'hCAFE_F00D, 5'd0, 5'd31, 16'h0, 1, 4'h0, 0, 0);
      check("R2 insert full", 1, 32'hCAFE_F00D, 1, 0);
      issue(3'd1, 32'h0000_0000, 32'h0000_0001, 5'd31, 5'd31, 16'h0, 1, 4'h0, 0, 0);
      check("R2 insert bit 31", 1, 32'h8000_0000, 1, 0);
   endtask

   task automatic t_order();
      issue(3'd0, 32'hFFFF_FFFF, 32'h0, 5'd4, 5'd3, 16'h0, 1, 4'h0, 0, 0);
      check("R3 clear hi<lo", 0, 32'h0, 0, 1);
      issue(3'd1, 32'hFFFF_FFFF, 32'h0, 5'd20, 5'd2, 16'h0, 1, 4'h0, 0, 0);
      check("R3 insert hi<lo", 0, 32'h0, 0, 1);
   endtask

   task automatic t_extract();
      issue(3'd6, 32'h0, 32'hF0F0_1234, 5'd4, 5'd7, 16'h0, 1, 4'h0, 0, 0);
      check("R4 uext 8 bits", 1, 32'h0000_0023, 1, 0);
      issue(3'd6, 32'h0, 32'h8765_4321, 5'd0, 5'd31, 16'h0, 1, 4'h0, 0, 0);
      check("R4 uext full", 1, 32'h8765_4321, 1, 0);
      issue(3'd4, 32'h0, 32'h0000_0F00, 5'd8, 5'd3, 16'h0, 1, 4'h0, 0, 0);
      check("R5 sext negative", 1, 32'hFFFF_FFFF, 1, 0);
      issue(3'd4, 32'h0, 32'h0000_0700, 5'd8, 5'd3, 16'h0, 1, 4'h0, 0, 0);
      check("R5 sext positive", 1, 32'h0000_0007, 1, 0);
      issue(3'd4, 32'h0, 32'h8000_0000, 5'd28, 5'd3, 16'h0, 1, 4'h0, 0, 0);
      check("R5 sext top field", 1, 32'hFFFF_FFF8, 1, 0);
      issue(3'd4, 32'h0, 32'h0000_0001, 5'd0, 5'd0, 16'h0, 1, 4'h0, 0, 0);
      check("R5 sext one bit", 1, 32'hFFFF_FFFF, 1, 0);
   endtask

   task automatic t_ext_range();
      issue(3'd4, 32'h0, 32'hFFFF_FFFF, 5'd28, 5'd4, 16'h0, 1, 4'h0, 0, 0);
      check("R6 sext overrun", 0, 32'h0, 0, 1);
      issue(3'd6, 32'h0, 32'hFFFF_FFFF, 5'd31, 5'd1, 16'h0, 1, 4'h0, 0, 0);
      check("R6 uext overrun", 0, 32'h0, 0, 1);
   endtask

   task automatic t_clz();
      issue(3'd2, 32'h0, 32'h0000_0000, 5'd0, 5'd0, 16'h0, 1, 4'h0, 0, 0);
      check("R7 clz zero", 1, 32'd32, 1, 0);
      issue(3'd2, 32'h0, 32'h0001_0000, 5'd0, 5'd0, 16'h0, 1, 4'h0, 0, 0);
      check("R7 clz mid", 1, 32'd15, 1, 0);
      issue(3'd2, 32'h0, 32'h8000_0000, 5'd0, 5'd0, 16'h0, 1, 4'h0, 0, 0);
      check("R7 clz top", 1, 32'd0, 1, 0);
      issue(3'd2, 32'h0, 32'h0000_0001, 5'd0, 5'd0, 16'h0, 1, 4'h0, 0, 0);
      check("R7 clz one", 1, 32'd31, 1, 0);
   endtask

   task automatic t_movhi();
      issue(3'd3, 32'hDEAD_BEEF, 32'h0, 5'd0, 5'd0, 16'h1234, 1, 4'h0, 0, 0);
      check("R8 move-top", 1, 32'h1234_BEEF, 1, 0);
   endtask

   task automatic t_select();
      issue(3'd5, 32'h1122_3344, 32'hAABB_CCDD, 5'd0, 5'd0, 16'h0, 1, 4'b0101, 0, 0);
      check("R9 select 0101", 1, 32'hAA22_CC44, 1, 0);
      issue(3'd5, 32'h1122_3344, 32'hAABB_CCDD, 5'd0, 5'd0, 16'h0, 1, 4'b1111, 0, 0);
      check("R9 select all first", 1, 32'h1122_3344, 1, 0);
      issue(3'd5, 32'h1122_3344, 32'hAABB_CCDD, 5'd0, 5'd0, 16'h0, 1, 4'b0000, 0, 0);
      check("R9 select all second", 1, 32'hAABB_CCDD, 1, 0);
   endtask

   task automatic t_pc();
      issue(3'd3, 32'h0, 32'h0, 5'd0, 5'd0, 16'hFFFF, 1, 4'h0, 1, 0);
      check("R10 dst pc move-top", 0, 32'h0, 0, 1);
      issue(3'd2, 32'h0, 32'h1, 5'd0, 5'd0, 16'h0, 1, 4'h0, 0, 1);
      check("R10 src pc clz", 0, 32'h0, 0, 1);
      issue(3'd5, 32'h0, 32'h1, 5'd0, 5'd0, 16'h0, 1, 4'h0, 0, 1);
      check("R10 src pc select", 0, 32'h0, 0, 1);
      issue(3'd0, 32'hFFFF_FFFF, 32'h0, 5'd0, 5'd7, 16'h0, 1, 4'h0, 0, 1);
      check("R10 src pc ignored by clear", 1, 32'hFFFF_FF00, 1, 0);
   endtask

   task automatic t_cond();
      issue(3'd0, 32'hFFFF_FFFF, 32'h0, 5'd0, 5'd7, 16'h0, 0, 4'h0, 0, 0);
      check("R11 cond fail", 0, 32'h0, 0, 0);
      issue(3'd0, 32'hFFFF_FFFF, 32'h0, 5'd7, 5'd0, 16'h0, 0, 4'h0, 0, 0);
      check("R11 cond fail still unpredictable", 0, 32'h0, 0, 1);
   endtask

   task automatic t_idle_and_rsvd();
      issue(3'd7, 32'h0, 32'h0, 5'd0, 5'd0, 16'h0, 1, 4'h0, 0, 0);
      check("R13 reserved opcode", 0, 32'h0, 0, 1);
      @(negedge clk);
      check("R12 idle after op", 0, 32'h0, 0, 0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_clear();
      t_insert();
      t_order();
      t_extract();
      t_ext_range();
      t_clz();
      t_movhi();
      t_select();
      t_pc();
      t_cond();
      t_idle_and_rsvd();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule